// File: doc/BRIEF.md
# Sixteen-bit timer with capture, auto-reload and serial baud clock

This block is a 16-bit up-counter governed by one 8-bit control byte. It counts either a divided system-rate enable or falling edges on an external count pin. A falling edge on a separate trigger pin can either latch the running count into a capture/reload register or load the count from that register. Two flags record events: an overflow flag and an external-event flag. Their OR drives an interrupt request. Software clears each flag by writing the control byte.

When either serial clock select bit is set, the timer becomes a baud generator. It counts on the oscillator-rate enable, always reloads on overflow, and sends every overflow to the serial port as a one-cycle pulse. In this mode the overflow flag stays clear and trigger-pin events are blocked.

Software reaches the control byte, the two count bytes and the two capture bytes through a byte-wide write port and a combinational read port. Both ports select the register with a 3-bit code.

Top module: `tmr16_ctl`

## Requirements
- R1: Register select codes are 0 for control, 1 for count low byte, 2 for count high byte, 3 for capture low byte and 4 for capture high byte. All registers reset to 0, and every written value reads back.
- R2: The overflow flag (control bit 7) is set when the count wraps past 0xFFFF outside baud mode. It stays set until software writes a 0 to it.
- R3: The overflow flag is never set while receive select (bit 5) or transmit select (bit 4) is 1.
- R4: With run (bit 2) = 1 and counter select (bit 1) = 0 outside baud mode, the count increments once per `tick12` pulse. With run = 0, the count holds.
- R5: With bit 1 = 1, the count increments once per falling edge of `cnt_pin`, seen through a two-flop synchronizer. `tick12` has no effect in this setting.
- R6: On overflow with reload select (bit 0) = 0, the count loads the capture register. With bit 0 = 1, the count wraps to 0 and the capture register is unchanged.
- R7: With external enable (bit 3) = 1, a synchronized falling edge on `trig_pin` sets the external flag (bit 6). It also latches the count into the capture register when bit 0 = 1, or loads the count from that register when bit 0 = 0. The external flag is sticky until software writes 0 to it.
- R8: A falling edge on `trig_pin` changes nothing when bit 3 = 0, or when bit 5 or bit 4 is 1.
- R9: In baud mode (bit 5 or bit 4 set), the count advances on `tick1` and ignores `tick12`. Every overflow reloads from the capture register. `ovf_pulse` is high for the one cycle that follows each overflow.
- R10: `irq` is 1 exactly when bit 7 or bit 6 of the control byte is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick12 | input | 1 | Count enable at one twelfth of the oscillator rate |
| tick1 | input | 1 | Count enable at the oscillator rate (baud mode) |
| cnt_pin | input | 1 | External count input, falling edges counted |
| trig_pin | input | 1 | External capture/reload trigger, falling edge active |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data for `rd_sel` |
| ovf_pulse | output | 1 | One-cycle overflow pulse to the serial port |
| irq | output | 1 | Timer interrupt request |

## Verification
The bench drives the count to 0xFFFF in reload, capture and baud modes.

- Wrapping to 0 instead of reloading, or the reverse, shows up as a wrong count byte.
- A design that forgets baud-mode suppression raises bit 7 and `irq` when it should not.
- Trigger edges are applied with external enable off and again in baud mode. A design that lets them through alters the capture or count register.
- Rising edges and `tick12` pulses are applied in counter mode. Any stray increment from them changes the count read back.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
   localparam int CB_OVF  = 7;
   localparam int CB_EXT  = 6;
   localparam int CB_RXS  = 5;
   localparam int CB_TXS  = 4;
   localparam int CB_EXEN = 3;
   localparam int CB_RUN  = 2;
   localparam int CB_CT   = 1;
   localparam int CB_CAP  = 0;
   localparam int CTL_W   = 8;
endpackage

// File: rtl/tmr16_sync_edge.sv
module tmr16_sync_edge #(
   parameter int STAGES = 2,
   parameter bit IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("tmr16_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= {STAGES{IDLE}};
         prev_q <= IDLE;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign fall = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/tmr16_ctrl_reg.sv
module tmr16_ctrl_reg
   import tmr16_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             set_ovf,
   input  logic             set_ext,
   output logic [CTL_W-1:0] ctl
);
   // a hardware set in the same cycle as a software write wins, so no event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         if (wr)      ctl         <= wdata;
         if (set_ovf) ctl[CB_OVF] <= 1'b1;
         if (set_ext) ctl[CB_EXT] <= 1'b1;
      end
   end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
   parameter int CNT_W = 16,
   localparam int BYTES = CNT_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             reload_on_ovf,
   input  logic             trig_cap,
   input  logic             trig_load,
   input  logic [BYTES-1:0] wr_cnt_b,
   input  logic [BYTES-1:0] wr_cap_b,
   input  logic [7:0]       wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap,
   output logic             ovf
);
   logic [CNT_W-1:0] cnt_d, cap_d;

   assign ovf = inc & (&cnt);

   always_comb begin
      cnt_d = cnt;
      if (trig_load)
         cnt_d = cap;
      else if (ovf)
         cnt_d = reload_on_ovf ? cap : '0;
      else if (inc)
         cnt_d = cnt + 1'b1;
      cap_d = trig_cap ? cnt : cap;
      // software byte writes override hardware updates of the same register
      for (int b = 0; b < BYTES; b++) begin
         if (wr_cnt_b[b]) cnt_d[b*8 +: 8] = wdata;
         if (wr_cap_b[b]) cap_d[b*8 +: 8] = wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         cap <= '0;
      end else begin
         cnt <= cnt_d;
         cap <= cap_d;
      end
   end
endmodule

// File: rtl/tmr16_ctl.sv
module tmr16_ctl
   import tmr16_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int BYTES      = CNT_W / 8,
   localparam int SEL_W      = $clog2(2 * BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick12,
   input  logic             tick1,
   input  logic             cnt_pin,
   input  logic             trig_pin,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [7:0]       wr_data,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [7:0]       rd_data,
   output logic             ovf_pulse,
   output logic             irq
);
   generate
      if (CNT_W < 8 || (CNT_W % 8) != 0) begin : g_bad_w
         $error("tmr16_ctl: CNT_W must be a positive multiple of 8");
      end
   endgenerate

   logic [CTL_W-1:0] ctl_q;
   logic [CNT_W-1:0] cnt_q, cap_q;
   logic [BYTES-1:0] wr_cnt_b, wr_cap_b;
   logic cnt_fall, trig_fall, baud, step_src, inc, ovf, trig_ok, ctl_wr;

   tmr16_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cnt_edge (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall));

   tmr16_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_trig_edge (
      .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall));

   assign ctl_wr = wr_en && (wr_sel == '0);

   generate
      for (genvar b = 0; b < BYTES; b++) begin : g_wdec
         assign wr_cnt_b[b] = wr_en && (wr_sel == SEL_W'(1 + b));
         assign wr_cap_b[b] = wr_en && (wr_sel == SEL_W'(1 + BYTES + b));
      end
   endgenerate

   assign baud     = ctl_q[CB_RXS] | ctl_q[CB_TXS];
   assign step_src = ctl_q[CB_CT] ? cnt_fall : (baud ? tick1 : tick12);
   assign inc      = ctl_q[CB_RUN] & step_src;
   assign trig_ok  = trig_fall & ctl_q[CB_EXEN] & ~baud;

   tmr16_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .inc(inc),
      .reload_on_ovf(baud | ~ctl_q[CB_CAP]),
      .trig_cap(trig_ok & ctl_q[CB_CAP]),
      .trig_load(trig_ok & ~ctl_q[CB_CAP]),
      .wr_cnt_b(wr_cnt_b), .wr_cap_b(wr_cap_b), .wdata(wr_data),
      .cnt(cnt_q), .cap(cap_q), .ovf(ovf));

   tmr16_ctrl_reg u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(wr_data),
      .set_ovf(ovf & ~baud), .set_ext(trig_ok), .ctl(ctl_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_pulse <= 1'b0;
      else        ovf_pulse <= ovf;
   end

   assign irq = ctl_q[CB_OVF] | ctl_q[CB_EXT];

   always_comb begin
      rd_data = '0;
      if (rd_sel == '0) rd_data = ctl_q;
      for (int b = 0; b < BYTES; b++) begin
         if (rd_sel == SEL_W'(1 + b))         rd_data = cnt_q[b*8 +: 8];
         if (rd_sel == SEL_W'(1 + BYTES + b)) rd_data = cap_q[b*8 +: 8];
      end
   end
endmodule

// File: rtl/tmr16_ctl_chk.sv
module tmr16_ctl_chk
   import tmr16_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [SEL_W-1:0] wr_sel,
   input logic             ovf_pulse,
   input logic [CTL_W-1:0] ctl,
   input logic [CNT_W-1:0] cnt
);
   localparam int BYTES = CNT_W / 8;
   logic ctl_wr, cnt_wr;
   assign ctl_wr = wr_en && (wr_sel == '0);
   assign cnt_wr = wr_en && (wr_sel != '0) && (wr_sel <= SEL_W'(BYTES));

   p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[CB_OVF] && !ctl_wr) |=> ctl[CB_OVF]);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[CB_OVF] && (ctl[CB_RXS] || ctl[CB_TXS]) && !ctl_wr) |=> !ctl[CB_OVF]);

   p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[CB_RUN] && !ctl[CB_EXEN] && !cnt_wr) |=> $stable(cnt));

   p_ext_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[CB_EXT] && !ctl_wr) |=> ctl[CB_EXT]);

   p_trig_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[CB_EXT] && !ctl[CB_EXEN] && !ctl_wr) |=> !ctl[CB_EXT]);

   p_pulse_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> $past(ctl[CB_RUN]));
endmodule

bind tmr16_ctl tmr16_ctl_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .ovf_pulse(ovf_pulse), .ctl(ctl_q), .cnt(cnt_q));

// File: tb/tmr16_ctl_tb.sv
module tmr16_ctl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick12 = 1'b0, tick1 = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
   logic wr_en = 1'b0;
   logic [2:0] wr_sel = '0, rd_sel = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic ovf_pulse, irq;
   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   tmr16_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .tick12(tick12), .tick1(tick1),
      .cnt_pin(cnt_pin), .trig_pin(trig_pin), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .ovf_pulse(ovf_pulse), .irq(irq));

   // op: 0 write, 1 read check, 2 tick12 pulses, 3 tick1 pulses, 4 irq check
   localparam int NV = 53;
   localparam logic [25:0] VEC [NV] = '{
      {3'd0,3'd1,8'hFE,8'h00,4'd1}, {3'd0,3'd2,8'hFF,8'h00,4'd1},
      {3'd0,3'd3,8'h34,8'h00,4'd1}, {3'd0,3'd4,8'h12,8'h00,4'd1},
      {3'd0,3'd0,8'h04,8'h00,4'd1},
      {3'd1,3'd0,8'h00,8'h04,4'd1}, {3'd1,3'd3,8'h00,8'h34,4'd1},   // R1
      {3'd1,3'd4,8'h00,8'h12,4'd1},
      {3'd2,3'd0,8'd1,8'h00,4'd4},  {3'd1,3'd1,8'h00,8'hFF,4'd4},    // R4
      {3'd1,3'd2,8'h00,8'hFF,4'd4},
      {3'd2,3'd0,8'd1,8'h00,4'd6},  {3'd1,3'd1,8'h00,8'h34,4'd6},    // R6 reload
      {3'd1,3'd2,8'h00,8'h12,4'd6}, {3'd1,3'd0,8'h00,8'h84,4'd2},    // R2
      {3'd4,3'd0,8'h00,8'h01,4'd10},                                 // R10
      {3'd2,3'd0,8'd1,8'h00,4'd4},  {3'd1,3'd0,8'h00,8'h84,4'd2},
      {3'd1,3'd1,8'h00,8'h35,4'd4},
      {3'd0,3'd0,8'h04,8'h00,4'd2}, {3'd1,3'd0,8'h00,8'h04,4'd2},
      {3'd4,3'd0,8'h00,8'h00,4'd10},
      {3'd0,3'd0,8'h00,8'h00,4'd4}, {3'd2,3'd0,8'd3,8'h00,4'd4},
      {3'd1,3'd1,8'h00,8'h35,4'd4},                                  // R4 hold
      {3'd0,3'd1,8'hFF,8'h00,4'd6}, {3'd0,3'd2,8'hFF,8'h00,4'd6},
      {3'd0,3'd0,8'h05,8'h00,4'd6}, {3'd2,3'd0,8'd1,8'h00,4'd6},
      {3'd1,3'd1,8'h00,8'h00,4'd6}, {3'd1,3'd2,8'h00,8'h00,4'd6},    // R6 wrap
      {3'd1,3'd0,8'h00,8'h85,4'd2}, {3'd1,3'd3,8'h00,8'h34,4'd6},
      {3'd0,3'd0,8'h00,8'h00,4'd9},
      {3'd0,3'd3,8'hF0,8'h00,4'd9}, {3'd0,3'd4,8'hFF,8'h00,4'd9},
      {3'd0,3'd1,8'hFE,8'h00,4'd9}, {3'd0,3'd2,8'hFF,8'h00,4'd9},
      {3'd0,3'd0,8'h14,8'h00,4'd9}, {3'd3,3'd0,8'd1,8'h00,4'd9},
      {3'd1,3'd1,8'h00,8'hFF,4'd9}, {3'd2,3'd0,8'd2,8'h00,4'd9},     // R9
      {3'd1,3'd1,8'h00,8'hFF,4'd9}, {3'd3,3'd0,8'd1,8'h00,4'd9},
      {3'd1,3'd1,8'h00,8'hF0,4'd9}, {3'd1,3'd0,8'h00,8'h14,4'd3},    // R3
      {3'd4,3'd0,8'h00,8'h00,4'd3},
      {3'd0,3'd0,8'h24,8'h00,4'd3}, {3'd0,3'd1,8'hFF,8'h00,4'd3},
      {3'd0,3'd2,8'hFF,8'h00,4'd3}, {3'd3,3'd0,8'd1,8'h00,4'd3},
      {3'd1,3'd0,8'h00,8'h24,4'd3}, {3'd1,3'd1,8'h00,8'hF0,4'd9}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input string req, input logic [2:0] s, input logic [7:0] exp);
      @(negedge clk); rd_sel = s; #1;
      chk(req, rd_data, exp);
   endtask

   task automatic pulse12(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick12 = 1'b1;
         @(negedge clk); tick12 = 1'b0;
      end
   endtask

   task automatic pulse1(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick1 = 1'b1;
         @(negedge clk); tick1 = 1'b0;
      end
   endtask

   task automatic trig_fall();
      @(negedge clk); trig_pin = 1'b0;
      repeat (5) @(negedge clk);
      trig_pin = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic cnt_fall();
      @(negedge clk); cnt_pin = 1'b0;
      repeat (4) @(negedge clk);
      cnt_pin = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int s = 0; s < 5; s++) rd("R1", 3'(s), 8'h00);
      chk("R10", {7'd0, irq}, 8'h00);
      chk("R9", {7'd0, ovf_pulse}, 8'h00);

      for (int v = 0; v < NV; v++) begin
         logic [2:0] op, sel;
         logic [7:0] dat, exp;
         logic [3:0] rq;
         string tag;
         {op, sel, dat, exp, rq} = VEC[v];
         tag = $sformatf("R%0d", rq);
         case (op)
            3'd0: wr(sel, dat);
            3'd1: rd(tag, sel, exp);
            3'd2: pulse12(int'(dat));
            3'd3: pulse1(int'(dat));
            default: begin @(negedge clk); chk(tag, {7'd0, irq}, exp); end
         endcase
      end

      // R7 capture on trigger
      wr(3'd0, 8'h00); wr(3'd1, 8'hCD); wr(3'd2, 8'hAB); wr(3'd0, 8'h09);
      trig_fall();
      rd("R7", 3'd3, 8'hCD); rd("R7", 3'd4, 8'hAB); rd("R7", 3'd0, 8'h49);
      chk("R10", {7'd0, irq}, 8'h01);
      // R8 trigger ignored with external enable off
      wr(3'd0, 8'h01); wr(3'd1, 8'h11); wr(3'd2, 8'h11);
      trig_fall();
      rd("R8", 3'd3, 8'hCD); rd("R8", 3'd1, 8'h11); rd("R8", 3'd0, 8'h01);
      // R7 reload on trigger
      wr(3'd0, 8'h08); wr(3'd1, 8'h05); wr(3'd2, 8'h00);
      trig_fall();
      rd("R7", 3'd1, 8'hCD); rd("R7", 3'd2, 8'hAB); rd("R7", 3'd0, 8'h48);
      // R8 trigger blocked in baud mode
      wr(3'd0, 8'h28); wr(3'd1, 8'h07); wr(3'd2, 8'h00);
      trig_fall();
      rd("R8", 3'd1, 8'h07); rd("R8", 3'd0, 8'h28);
      // R5 counter mode
      wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h06);
      cnt_fall(); cnt_fall(); cnt_fall();
      rd("R5", 3'd1, 8'h03);
      pulse12(2);
      rd("R5", 3'd1, 8'h03);
      // R9 overflow pulse timing in baud mode
      wr(3'd0, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
      wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd0, 8'h14);
      @(negedge clk); tick1 = 1'b1;
      @(negedge clk); tick1 = 1'b0;
      chk("R9", {7'd0, ovf_pulse}, 8'h01);
      @(negedge clk);
      chk("R9", {7'd0, ovf_pulse}, 8'h00);
      rd("R9", 3'd1, 8'h00); rd("R3", 3'd0, 8'h14);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule